// File: doc/BRIEF.md
# Five-Step Multicycle Processor Core

This block is a small 32-bit processor core. Every instruction takes exactly five clock steps: fetch, register read, execute, memory access and register writeback. The core holds a program counter, an instruction register, a 32-entry by 32-bit register file, staging registers between the steps, and a result register that captures the ALU output before the memory step. A single word-addressed memory port carries both instruction fetches and data loads and stores. The memory is outside the core and returns read data in the same cycle as the address.

Eight operations are decoded. Three use the register format: add, subtract and bitwise AND. The other five use the immediate format: copy, add immediate, load, store and load immediate. Any other opcode runs through the five steps and writes nothing. The core has no branches, so after reset it walks through consecutive words starting at address 0.

Top module: `quint_core`

## Requirements
- R1: While `rst` is high, `mem_we` is 0 and `mem_addr` is 0. The first fetch after release reads word 0.
- R2: The steps repeat in a fixed cycle of five. Count the cycles since reset release as c. When c mod 5 = 0, `mem_addr` presents the fetch address, and that address equals c/5, so the program counter advances by one word per instruction.
- R3: All 32 registers can be written and read back independently. Registers not yet written read as zero after reset.
- R4: Register-format words are laid out as opcode[31:26], dest[25:21], src1[20:16] and src2[15:11]; bits [10:0] are ignored. Opcode 000000 sets dest to src1+src2, 010000 sets dest to src1−src2, and 011000 sets dest to src1 AND src2. The word 0x00611000 sets r3 to r1+r2.
- R5: Opcode 001000 copies src1 into dest.
- R6: Opcode 100000 sets dest to src1 plus the sign-extended immediate in bits [15:0].
- R7: Opcode 111000 loads the sign-extended immediate into dest.
- R8: Opcode 101000 loads memory[src1 + sext(imm)] into dest. The word 0xA0220007 sets r1 to mem[r2+7].
- R9: Opcode 110000 writes the dest register to memory[src1 + sext(imm)]. `mem_we` is high exactly once per store, in the cycle where c mod 5 = 3. No register is written by a store.
- R10: Any opcode outside the eight above changes no register and no memory word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | ADDR_W | Word address: the fetch address in step 1, the data address otherwise |
| mem_rdata | input | 32 | Read data, valid in the same cycle as `mem_addr` |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Write strobe |

## Verification
The bench builds the core with `ADDR_W` = 8, so the memory is 256 words. Programs fit in the lower half and results land in the upper half. It keeps the default of 32 registers, so one program can write every register with a load-immediate and then store all 32 of them, covering the whole register file.

For each of six operand pairs, the bench runs every operation once. The pairs cover carry, borrow, sign-bit and all-ones cases. Each run also includes an undefined opcode, a store with a negative offset, and the two fixed instruction words. After each run the bench compares the entire upper half of memory against values it computes itself.

// File: rtl/quint_pkg.sv
package quint_pkg;

    localparam int WORD_W = 32;
    localparam int IDX_W  = 5;
    localparam int IMM_W  = 16;
    localparam int OPC_W  = 6;

    localparam logic [OPC_W-1:0] OPC_ADD = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_SUB = 6'b010000;
    localparam logic [OPC_W-1:0] OPC_AND = 6'b011000;
    localparam logic [OPC_W-1:0] OPC_MOV = 6'b001000;
    localparam logic [OPC_W-1:0] OPC_ADI = 6'b100000;
    localparam logic [OPC_W-1:0] OPC_LDA = 6'b101000;
    localparam logic [OPC_W-1:0] OPC_STA = 6'b110000;
    localparam logic [OPC_W-1:0] OPC_MVI = 6'b111000;

    typedef enum logic [2:0] {
        STEP_FETCH = 3'd0,
        STEP_READ  = 3'd1,
        STEP_ALU   = 3'd2,
        STEP_MEM   = 3'd3,
        STEP_WB    = 3'd4
    } step_e;

    typedef enum logic [2:0] {
        ALU_ADD    = 3'd0,
        ALU_SUB    = 3'd1,
        ALU_AND    = 3'd2,
        ALU_PASS_A = 3'd3,
        ALU_PASS_B = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic    valid;
        alu_op_e alu_op;
        logic    use_imm;
        logic    load;
        logic    store;
        logic    writes;
    } ctl_t;

endpackage

// File: rtl/quint_decode.sv
module quint_decode
    import quint_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output ctl_t             ctl
);

    always_comb begin
        ctl         = '0;
        ctl.alu_op  = ALU_ADD;
        case (opcode)
            OPC_ADD: begin ctl.valid = 1'b1; ctl.alu_op = ALU_ADD; end
            OPC_SUB: begin ctl.valid = 1'b1; ctl.alu_op = ALU_SUB; end
            OPC_AND: begin ctl.valid = 1'b1; ctl.alu_op = ALU_AND; end
            OPC_MOV: begin ctl.valid = 1'b1; ctl.alu_op = ALU_PASS_A; end
            OPC_ADI: begin ctl.valid = 1'b1; ctl.alu_op = ALU_ADD; ctl.use_imm = 1'b1; end
            OPC_MVI: begin ctl.valid = 1'b1; ctl.alu_op = ALU_PASS_B; ctl.use_imm = 1'b1; end
            OPC_LDA: begin
                ctl.valid   = 1'b1;
                ctl.alu_op  = ALU_ADD;
                ctl.use_imm = 1'b1;
                ctl.load    = 1'b1;
            end
            OPC_STA: begin
                ctl.valid   = 1'b1;
                ctl.alu_op  = ALU_ADD;
                ctl.use_imm = 1'b1;
                ctl.store   = 1'b1;
            end
            default: ctl.valid = 1'b0;
        endcase
        ctl.writes = ctl.valid && !ctl.store;
    end

endmodule

// File: rtl/quint_alu.sv
module quint_alu
    import quint_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);

    always_comb begin
        case (op)
            ALU_ADD:    y = a + b;
            ALU_SUB:    y = a - b;
            ALU_AND:    y = a & b;
            ALU_PASS_A: y = a;
            ALU_PASS_B: y = b;
            default:    y = '0;
        endcase
    end

endmodule

// File: rtl/quint_regfile.sv
module quint_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int RI_W = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [RI_W-1:0] ra_idx,
    input  logic [RI_W-1:0] rb_idx,
    input  logic            we,
    input  logic [RI_W-1:0] w_idx,
    input  logic [W-1:0]    w_data,
    output logic [W-1:0]    ra_data,
    output logic [W-1:0]    rb_data
);

    logic [NREG-1:0][W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            regs_d[w_idx] = w_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ra_data = regs_q[ra_idx];
    assign rb_data = regs_q[rb_idx];

    AST_RF_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> regs_q[$past(w_idx)] == $past(w_data)); // R3

    AST_RF_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(regs_q)); // R10

endmodule

// File: rtl/quint_core.sv
module quint_core
    import quint_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we
);

    typedef struct packed {
        step_e             step;
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] ir;
        logic [WORD_W-1:0] ra;
        logic [WORD_W-1:0] rb;
        logic [WORD_W-1:0] imm;
        logic [WORD_W-1:0] rz;
        logic [WORD_W-1:0] ry;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [OPC_W-1:0]  f_opc;
    logic [IDX_W-1:0]  f_dst, f_src1, f_src2;
    logic [IMM_W-1:0]  f_imm;
    ctl_t              ctl;
    logic [WORD_W-1:0] rf_a, rf_b, alu_b, alu_y;
    logic              rf_we;

    assign f_opc  = st_q.ir[31:26];
    assign f_dst  = st_q.ir[25:21];
    assign f_src1 = st_q.ir[20:16];
    assign f_src2 = st_q.ir[15:11];
    assign f_imm  = st_q.ir[15:0];

    quint_decode u_decode (
        .opcode (f_opc),
        .ctl    (ctl)
    );

    assign rf_we = (st_q.step == STEP_WB) && ctl.writes;

    quint_regfile #(
        .NREG (32),
        .W    (WORD_W)
    ) u_regfile (
        .clk     (clk),
        .rst     (rst),
        .ra_idx  (f_src1),
        .rb_idx  (ctl.store ? f_dst : f_src2),
        .we      (rf_we),
        .w_idx   (f_dst),
        .w_data  (st_q.ry),
        .ra_data (rf_a),
        .rb_data (rf_b)
    );

    assign alu_b = ctl.use_imm ? st_q.imm : st_q.rb;

    quint_alu #(
        .W (WORD_W)
    ) u_alu (
        .a  (st_q.ra),
        .b  (alu_b),
        .op (ctl.alu_op),
        .y  (alu_y)
    );

    always_comb begin
        st_d = st_q;
        case (st_q.step)
            STEP_FETCH: begin
                st_d.ir   = mem_rdata;
                st_d.pc   = st_q.pc + 1'b1;
                st_d.step = STEP_READ;
            end
            STEP_READ: begin
                st_d.ra   = rf_a;
                st_d.rb   = rf_b;
                st_d.imm  = {{(WORD_W-IMM_W){f_imm[IMM_W-1]}}, f_imm};
                st_d.step = STEP_ALU;
            end
            STEP_ALU: begin
                st_d.rz   = alu_y;
                st_d.step = STEP_MEM;
            end
            STEP_MEM: begin
                st_d.ry   = ctl.load ? mem_rdata : st_q.rz;
                st_d.step = STEP_WB;
            end
            STEP_WB: begin
                st_d.step = STEP_FETCH;
            end
            default: begin
                st_d.step = STEP_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr  = (st_q.step == STEP_FETCH) ? st_q.pc : st_q.rz[ADDR_W-1:0];
    assign mem_wdata = st_q.rb;
    assign mem_we    = (st_q.step == STEP_MEM) && ctl.store;

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (st_q.step == STEP_FETCH) |=> (st_q.pc - $past(st_q.pc)) == ADDR_W'(1)); // R2

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q.step != STEP_FETCH) |=> $stable(st_q.pc)); // R2

    AST_WB_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
        (st_q.step == STEP_WB) |=> (st_q.step == STEP_FETCH)); // R2

    AST_WB_FOLLOWS_MEM: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> $past(st_q.step) == STEP_MEM); // R2

    AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !rf_we); // R9

    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ctl.valid |-> (!mem_we && !rf_we)); // R10

    AST_ALU_SUB_INVERSE: assert property (@(posedge clk) disable iff (rst)
        (st_q.step == STEP_ALU && ctl.alu_op == ALU_SUB)
        |=> (st_q.rz + $past(alu_b)) == $past(st_q.ra)); // R4

    AST_ALU_AND_SUBSET: assert property (@(posedge clk) disable iff (rst)
        (st_q.step == STEP_ALU && ctl.alu_op == ALU_AND)
        |=> (st_q.rz & ~$past(st_q.ra)) == '0); // R4

endmodule

// File: tb/quint_core_bench.sv
module quint_core_bench;

    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam logic [31:0] FILL = 32'hFC00_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata, mem_wdata;
    logic          mem_we;

    logic [31:0] mem      [DEPTH];
    logic [31:0] exp_mem  [DEPTH];
    string       exp_tag  [DEPTH];
    bit          is_store [DEPTH];

    int plen, n_checks, n_fails, cyc, store_seen, store_want;
    bit running, finished;

    always #2.5 clk = ~clk;

    quint_core #(.ADDR_W(AW)) u_quint_core (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (rst) cyc <= 0; else cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(logic [5:0] op, int rd, int s1, int s2, logic [10:0] junk);
        return {op, 5'(rd), 5'(s1), 5'(s2), junk};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rd, int s1, logic [15:0] imm);
        return {op, 5'(rd), 5'(s1), imm};
    endfunction

    function automatic logic [31:0] sx(logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic put(input logic [31:0] w);
        mem[plen]      = w;
        is_store[plen] = (w[31:26] == 6'b110000);
        if (is_store[plen]) store_want++;
        plen++;
    endtask

    task automatic setexp(input int a, input logic [31:0] v, input string tag);
        exp_mem[a] = v;
        exp_tag[a] = tag;
    endtask

    task automatic clear_all();
        rst = 1'b1;
        plen = 0;
        store_want = 0;
        store_seen = 0;
        for (int a = 0; a < DEPTH; a++) begin
            mem[a]      = FILL;
            exp_mem[a]  = FILL;
            exp_tag[a]  = "R10 untouched";
            is_store[a] = 1'b0;
        end
    endtask

    // samples fetch address and write strobe away from the active edge
    always @(negedge clk) begin
        if (running && !rst) begin
            if (cyc % 5 == 0)
                check(mem_addr == AW'(cyc / 5), (cyc == 0) ? "R1 R2 fetch addr" : "R2 fetch addr",
                      32'(mem_addr), 32'(cyc / 5));
            if (mem_we) begin
                store_seen++;
                check((cyc % 5 == 3) && is_store[(cyc / 5) % DEPTH], "R9 strobe step",
                      32'(cyc % 5), 32'd3);
            end
        end
    end

    task automatic run_and_compare();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(mem_we == 1'b0, "R1 reset we", 32'(mem_we), 32'd0);
        check(mem_addr == '0, "R1 reset addr", 32'(mem_addr), 32'd0);
        rst = 1'b0;
        running = 1'b1;
        repeat (plen * 5 + 10) @(posedge clk);
        @(negedge clk);
        running = 1'b0;
        rst = 1'b1;
        check(store_seen == store_want, "R9 store count", 32'(store_seen), 32'(store_want));
        for (int a = DEPTH / 2; a < DEPTH; a++)
            check(mem[a] === exp_mem[a], exp_tag[a], mem[a], exp_mem[a]);
    endtask

    initial begin
        n_checks = 0;
        n_fails  = 0;
        running  = 1'b0;
        finished = 1'b0;

        // register-file sweep: R3 R7
        clear_all();
        for (int i = 1; i < 32; i++)
            put(enc_i(6'b111000, i, 0, 16'h8000 ^ 16'(i * 16'h0911)));
        for (int i = 0; i < 32; i++) begin
            put(enc_i(6'b110000, i, 0, 16'(128 + i)));
            setexp(128 + i, (i == 0) ? 32'd0 : sx(16'h8000 ^ 16'(i * 16'h0911)), "R3 R7 sweep");
        end
        run_and_compare();

        // operation sweep over operand pairs: R4 R5 R6 R8 R9 R10
        for (int k = 0; k < 6; k++) begin
            logic [15:0] a16, b16, c16;
            logic [31:0] sa, sb, dval;
            logic [5:0]  bad_op;
            case (k)
                0: begin a16 = 16'h0001; b16 = 16'h0002; bad_op = 6'b000001; end
                1: begin a16 = 16'h7FFF; b16 = 16'h0001; bad_op = 6'b111111; end
                2: begin a16 = 16'h8000; b16 = 16'hFFFF; bad_op = 6'b100100; end
                3: begin a16 = 16'h1234; b16 = 16'hABCD; bad_op = 6'b010001; end
                4: begin a16 = 16'hFFFF; b16 = 16'hFFFF; bad_op = 6'b001001; end
                default: begin a16 = 16'h5A5A; b16 = 16'hA5A5; bad_op = 6'b011111; end
            endcase
            c16  = 16'h8001 + 16'(k * 16'h1111);
            sa   = sx(a16);
            sb   = sx(b16);
            dval = 32'hC0DE_0000 + 32'(k);
            clear_all();
            mem[200]     = dval;
            exp_mem[200] = dval;
            exp_tag[200] = "R8 source word";
            put(enc_i(6'b111000, 1, 0, a16));
            put(enc_i(6'b111000, 2, 0, b16));
            put(enc_r(6'b000000, 3, 1, 2, 11'h7FF));
            put(enc_r(6'b010000, 4, 1, 2, 11'h2A5));
            put(enc_r(6'b011000, 5, 1, 2, 11'h000));
            put(enc_i(6'b001000, 6, 1, 16'hFFFF));
            put(enc_i(6'b100000, 7, 1, c16));
            put(enc_i(bad_op, 8, 1, 16'd130));
            put(enc_i(6'b110000, 3, 0, 16'd128));
            put(enc_i(6'b110000, 4, 0, 16'd129));
            put(enc_i(6'b110000, 5, 0, 16'd130));
            put(enc_i(6'b110000, 6, 0, 16'd131));
            put(enc_i(6'b110000, 7, 0, 16'd132));
            put(enc_i(6'b110000, 8, 0, 16'd133));
            put(enc_i(6'b111000, 2, 0, 16'd193));
            put(32'h0061_1000);
            put(32'hA022_0007);
            put(enc_i(6'b110000, 3, 0, 16'd134));
            put(enc_i(6'b110000, 1, 0, 16'd135));
            put(enc_i(6'b110000, 2, 2, 16'hFFF2));
            put(enc_i(6'b110000, 2, 0, 16'd136));
            setexp(128, sa + sb, "R4 add");
            setexp(129, sa - sb, "R4 sub");
            setexp(130, sa & sb, "R4 and");
            setexp(131, sa, "R5 mov");
            setexp(132, sa + sx(c16), "R6 adi");
            setexp(133, 32'd0, "R10 undefined opcode");
            setexp(134, sa + 32'd193, "R4 fixed word");
            setexp(135, dval, "R8 load");
            setexp(179, 32'd193, "R9 negative offset");
            setexp(136, 32'd193, "R9 no writeback");
            run_and_compare();
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule